// File: doc/BRIEF.md
# Crosspoint Switch Control Register Unit

This block holds the digital routing state for an eight-output, eight-input video crosspoint matrix. A host programs it through one of two interfaces, chosen by a mode pin. The parallel interface carries a three-bit output address and a four-bit command word. The serial interface shifts one bit per write strobe, and its shift output can feed the serial input of the next device in a chain. Every write lands in a front rank of registers. A transfer then copies the front rank into a back rank, and the back rank drives the matrix.

A transfer can come from a rising edge of the latch pin (edge mode), from the latch pin being held low (level mode), or from certain parallel commands. The back rank supplies, per output, a three-bit input select, an output enable (low means high impedance) and a flag that grounds the buffer input. A load-enable pin is passed straight through, with no clocking, to the resistive-load control. All pins are sampled on `clk`. Write and latch edges are detected against the value held one cycle earlier.

Top module: `xp_ctrl_regs`

## Requirements
- R1: After reset, every select reads 0, every output enable reads 0 (high impedance), every ground flag reads 0, and `ser_out` reads 0.
- R2: A parallel write with `cmd[3]`=0 stores `cmd[2:0]` as the select of output `addr` in the front rank and clears that output's ground flag. The outputs do not change until a transfer.
- R3: A write strobe rising edge is accepted only when `ce_n`=0 and `ce`=1. Otherwise neither rank changes.
- R4: Parallel commands 1000 and 1001 set the ground flag of output `addr` in the front rank.
- R5: With `edge_mode`=1, a rising edge of `latch` copies the front rank into the back rank. Without a transfer, the back rank holds.
- R6: With `edge_mode`=0, the back rank follows the front rank on every clock while `latch` is low, and holds while `latch` is high.
- R7: Command 1011 enables all outputs and command 1110 disables all outputs. Command 1100 enables output `addr` and command 1101 disables output `addr`. Each of these also transfers the front rank into the back rank in the same cycle, whatever the level of `latch`.
- R8: Command 1111 transfers the front rank into the back rank only if `latch` is high when the command is accepted.
- R9: Command 1010 changes no state.
- R10: With `ser_mode`=1, each accepted strobe shifts the 40-bit front rank left and takes `cmd[0]` into bit 0. Output k occupies bits 5k+4..5k+2 (select), 5k+1 (enable) and 5k (ground). `ser_out` presents bit 39, so the most significant bit leaves first.
- R11: `load_en` equals `load_en_in` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_mode | input | 1 | 1 selects serial mode, 0 selects parallel mode |
| wr | input | 1 | Write strobe; acts on its rising edge |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| addr | input | 3 | Output address (parallel mode) |
| cmd | input | 4 | Command word; bit 0 is the serial input in serial mode |
| edge_mode | input | 1 | 1 selects edge transfer, 0 selects level transfer |
| latch | input | 1 | Transfer control |
| load_en_in | input | 1 | Load-enable request |
| ser_out | output | 1 | Serial cascade output |
| load_en | output | 1 | Load-enable to the analog loads |
| sel_o | output | 24 | Input select of output k at bits 3k+2..3k |
| oe_o | output | 8 | Output enables, one bit per output |
| gnd_o | output | 8 | Input-ground flags, one bit per output |

## Verification
Parallel select writes go to several different outputs. Each is checked before and after a latch edge, which shows the front rank apart from the back rank. Commands are tried under opposite latch levels and in both transfer modes, which shows command-triggered, software-triggered, edge and level transfers apart. A 40-bit serial pattern with no repetition is shifted through. It checks bit order and field layout, and it checks `ser_out` after each shift. Strobes with each chip enable in turn inactive show whether the enable gating works.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int unsigned CMD_W = 4;
  typedef enum logic [2:0] {
    OP_GND0   = 3'b000,
    OP_GND1   = 3'b001,
    OP_NOP    = 3'b010,
    OP_ENALL  = 3'b011,
    OP_ENONE  = 3'b100,
    OP_DISONE = 3'b101,
    OP_DISALL = 3'b110,
    OP_SWLAT  = 3'b111
  } xp_op_e;
endpackage

// File: rtl/xp_rise.sv
module xp_rise #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= din;
  end

  assign rise = din & ~q;
endmodule

// File: rtl/xp_rank1.sv
module xp_rank1 import xp_pkg::*; #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned SLOT_W = SEL_W + 2,
  localparam int unsigned TOT_W  = N_OUT * SLOT_W,
  localparam int unsigned AW     = $clog2(N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              ser_mode,
  input  logic [AW-1:0]     addr,
  input  logic [SEL_W:0]    cmd,
  input  logic              latch,
  output logic [TOT_W-1:0]  r1_q,
  output logic [TOT_W-1:0]  r1_nxt,
  output logic              code_xfer
);
  logic [SEL_W-1:0] arg;
  int unsigned      base;

  assign arg  = cmd[SEL_W-1:0];
  assign base = 32'(addr) * SLOT_W;

  always_comb begin
    r1_nxt    = r1_q;
    code_xfer = 1'b0;
    if (wr_ok) begin
      if (ser_mode) begin
        r1_nxt = {r1_q[TOT_W-2:0], cmd[0]};
      end else if (!cmd[SEL_W]) begin
        r1_nxt[base+2 +: SEL_W] = arg;
        r1_nxt[base]            = 1'b0;
      end else begin
        case (xp_op_e'(arg))
          OP_GND0, OP_GND1: r1_nxt[base] = 1'b1;
          OP_ENALL: begin
            for (int k = 0; k < N_OUT; k++) r1_nxt[k*SLOT_W+1] = 1'b1;
            code_xfer = 1'b1;
          end
          OP_DISALL: begin
            for (int k = 0; k < N_OUT; k++) r1_nxt[k*SLOT_W+1] = 1'b0;
            code_xfer = 1'b1;
          end
          OP_ENONE: begin
            r1_nxt[base+1] = 1'b1;
            code_xfer      = 1'b1;
          end
          OP_DISONE: begin
            r1_nxt[base+1] = 1'b0;
            code_xfer      = 1'b1;
          end
          OP_SWLAT: code_xfer = latch;
          default:  code_xfer = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r1_q <= '0;
    else if (wr_ok) r1_q <= r1_nxt;
  end

  AST_R1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(r1_q)); // R3
  AST_SER_INGEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && ser_mode) |=> (r1_q[0] == $past(cmd[0]))); // R10
endmodule

// File: rtl/xp_rank2.sv
module xp_rank2 #(
  parameter int unsigned TOT_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_mode,
  input  logic              latch,
  input  logic              lat_rise,
  input  logic              code_xfer,
  input  logic [TOT_W-1:0]  r1_q,
  input  logic [TOT_W-1:0]  r1_nxt,
  output logic [TOT_W-1:0]  r2_q
);
  logic xfer;

  always_comb begin
    xfer = code_xfer;
    if (edge_mode) xfer = xfer | lat_rise;
    else           xfer = xfer | ~latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    r2_q <= '0;
    else if (xfer) r2_q <= r1_nxt;
  end

  AST_R2_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (r2_q == r1_q)); // R5
  AST_R2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !lat_rise && !code_xfer) |=> $stable(r2_q)); // R5
endmodule

// File: rtl/xp_ctrl_regs.sv
module xp_ctrl_regs #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned SLOT_W = SEL_W + 2,
  localparam int unsigned TOT_W  = N_OUT * SLOT_W,
  localparam int unsigned AW     = $clog2(N_OUT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_mode,
  input  logic                    wr,
  input  logic                    ce_n,
  input  logic                    ce,
  input  logic [AW-1:0]           addr,
  input  logic [SEL_W:0]          cmd,
  input  logic                    edge_mode,
  input  logic                    latch,
  input  logic                    load_en_in,
  output logic                    ser_out,
  output logic                    load_en,
  output logic [N_OUT*SEL_W-1:0]  sel_o,
  output logic [N_OUT-1:0]        oe_o,
  output logic [N_OUT-1:0]        gnd_o
);
  logic [1:0]       rst_sync;
  logic             rst_i;
  logic             wr_rise, lat_rise, wr_ok, code_xfer;
  logic [TOT_W-1:0] r1_q, r1_nxt, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  xp_rise #(.RST_VAL(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(rst_i), .din(wr), .rise(wr_rise));
  xp_rise #(.RST_VAL(1'b1)) u_lat_edge (
    .clk(clk), .rst_n(rst_i), .din(latch), .rise(lat_rise));

  assign wr_ok = wr_rise & ~ce_n & ce;

  xp_rank1 #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_rank1 (
    .clk(clk), .rst_n(rst_i), .wr_ok(wr_ok), .ser_mode(ser_mode),
    .addr(addr), .cmd(cmd), .latch(latch),
    .r1_q(r1_q), .r1_nxt(r1_nxt), .code_xfer(code_xfer));

  xp_rank2 #(.TOT_W(TOT_W)) u_rank2 (
    .clk(clk), .rst_n(rst_i), .edge_mode(edge_mode), .latch(latch),
    .lat_rise(lat_rise), .code_xfer(code_xfer),
    .r1_q(r1_q), .r1_nxt(r1_nxt), .r2_q(r2_q));

  assign ser_out = r1_q[TOT_W-1];
  assign load_en = load_en_in;

  for (genvar k = 0; k < N_OUT; k++) begin : g_slot
    assign sel_o[k*SEL_W +: SEL_W] = r2_q[k*SLOT_W+2 +: SEL_W];
    assign oe_o[k]                 = r2_q[k*SLOT_W+1];
    assign gnd_o[k]                = r2_q[k*SLOT_W];
  end

  AST_SER_CASCADE: assert property (@(posedge clk) disable iff (!rst_i)
    (ser_mode && wr_ok) |=> (ser_out == $past(r1_q[TOT_W-2]))); // R10
endmodule

// File: tb/xp_ctrl_regs_bench.sv
module xp_ctrl_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_mode = 1'b0, wr = 1'b0, ce_n = 1'b0, ce = 1'b1;
  logic [2:0] addr = '0;
  logic [3:0] cmd = '0;
  logic edge_mode = 1'b1, latch = 1'b0, load_en_in = 1'b0;
  logic ser_out, load_en;
  logic [23:0] sel_o;
  logic [7:0] oe_o, gnd_o;

  int total = 0, bad = 0;
  logic [39:0] m1 = '0, m2 = '0;

  typedef struct {
    logic [23:0] sel;
    logic [7:0]  oe;
    logic [7:0]  gnd;
    logic        so;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  xp_ctrl_regs u_xp_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .wr(wr), .ce_n(ce_n),
    .ce(ce), .addr(addr), .cmd(cmd), .edge_mode(edge_mode), .latch(latch),
    .load_en_in(load_en_in), .ser_out(ser_out), .load_en(load_en),
    .sel_o(sel_o), .oe_o(oe_o), .gnd_o(gnd_o));

  task automatic expect_now(string tag);
    exp_t e;
    for (int k = 0; k < 8; k++) begin
      e.sel[k*3 +: 3] = m2[k*5+2 +: 3];
      e.oe[k]         = m2[k*5+1];
      e.gnd[k]        = m2[k*5];
    end
    e.so  = m1[39];
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (sel_o !== e.sel || oe_o !== e.oe || gnd_o !== e.gnd || ser_out !== e.so) begin
        bad++;
        $display("FAIL %s: sel=%h oe=%h gnd=%h so=%b expected sel=%h oe=%h gnd=%h so=%b",
                 e.tag, sel_o, oe_o, gnd_o, ser_out, e.sel, e.oe, e.gnd, e.so);
      end
    end
  end

  // parallel write; model mirrors the requirements
  task automatic pwrite(input logic [2:0] a, input logic [3:0] c, input bit ok, string tag);
    bit xf;
    int b;
    @(negedge clk); addr = a; cmd = c; wr = 1'b1;
    @(posedge clk); #1;
    xf = 0; b = a * 5;
    if (ok) begin
      if (!c[3]) begin m1[b+2 +: 3] = c[2:0]; m1[b] = 1'b0; end
      else case (c[2:0])
        3'b000, 3'b001: m1[b] = 1'b1;
        3'b011: begin for (int k = 0; k < 8; k++) m1[k*5+1] = 1'b1; xf = 1; end
        3'b110: begin for (int k = 0; k < 8; k++) m1[k*5+1] = 1'b0; xf = 1; end
        3'b100: begin m1[b+1] = 1'b1; xf = 1; end
        3'b101: begin m1[b+1] = 1'b0; xf = 1; end
        3'b111: xf = latch;
        default: ;
      endcase
    end
    if (xf || (!edge_mode && !latch)) m2 = m1;
    @(negedge clk); wr = 1'b0;
    expect_now(tag);
  endtask

  task automatic sbit(input logic bv, string tag);
    @(negedge clk); cmd = {3'b111, bv}; wr = 1'b1;
    @(posedge clk); #1;
    m1 = {m1[38:0], bv};
    if (!edge_mode && !latch) m2 = m1;
    @(negedge clk); wr = 1'b0;
    expect_now(tag);
  endtask

  task automatic set_latch(input logic v, string tag);
    logic prev;
    prev = latch;
    @(negedge clk); latch = v;
    @(posedge clk); #1;
    if (edge_mode && v && !prev) m2 = m1;
    if (!edge_mode && !v) m2 = m1;
    expect_now(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    expect_now("R1 reset state");

    pwrite(3'd3, 4'b0101, 1, "R2 select held in front rank");
    pwrite(3'd0, 4'b0111, 1, "R2 second select held");
    set_latch(1'b1, "R5 latch rise transfers");
    set_latch(1'b0, "R5 latch fall holds");

    pwrite(3'd3, 4'b1100, 1, "R7 enable one transfers");

    ce_n = 1'b1;
    pwrite(3'd3, 4'b0001, 0, "R3 ce_n high ignored");
    ce_n = 1'b0; ce = 1'b0;
    pwrite(3'd3, 4'b0010, 0, "R3 ce low ignored");
    ce = 1'b1;
    set_latch(1'b1, "R3 nothing pending after gated writes");
    set_latch(1'b0, "R3 idle");

    pwrite(3'd0, 4'b1000, 1, "R4 ground code 1000 pending");
    pwrite(3'd5, 4'b1001, 1, "R4 ground code 1001 pending");
    set_latch(1'b1, "R4 ground flags transferred");
    set_latch(1'b0, "R4 idle");
    pwrite(3'd0, 4'b0110, 1, "R2 select clears ground flag pending");

    pwrite(3'd6, 4'b1010, 1, "R9 code 1010 no change");
    pwrite(3'd1, 4'b0010, 1, "R8 pending select");
    pwrite(3'd1, 4'b1111, 1, "R8 soft latch with latch low no transfer");
    set_latch(1'b1, "R5 latch rise transfers pending");
    pwrite(3'd2, 4'b0011, 1, "R8 pending select with latch high");
    pwrite(3'd2, 4'b1111, 1, "R8 soft latch with latch high transfers");
    set_latch(1'b0, "R5 idle");

    pwrite(3'd4, 4'b1011, 1, "R7 enable all");
    pwrite(3'd4, 4'b1101, 1, "R7 disable one");
    pwrite(3'd4, 4'b1110, 1, "R7 disable all");
    pwrite(3'd7, 4'b1100, 1, "R7 enable output 7");

    edge_mode = 1'b0;
    pwrite(3'd2, 4'b0110, 1, "R6 level low follows");
    set_latch(1'b1, "R6 latch high");
    pwrite(3'd2, 4'b0100, 1, "R6 level high holds");
    set_latch(1'b0, "R6 latch low releases");
    edge_mode = 1'b1;

    ser_mode = 1'b1;
    begin
      logic [39:0] pat;
      pat = 40'hA5_C3_96_0F_E1;
      for (int i = 39; i >= 0; i--) sbit(pat[i], "R10 serial shift and ser_out");
    end
    set_latch(1'b1, "R10 serial frame decoded");
    set_latch(1'b0, "R10 idle");
    ser_mode = 1'b0;

    for (int i = 0; i < 2; i++) begin
      @(negedge clk); load_en_in = ~load_en_in; #1;
      total++;
      if (load_en !== load_en_in) begin
        bad++;
        $display("FAIL R11 load_en=%b expected %b", load_en, load_en_in);
      end
    end

    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule